// File: doc/BRIEF.md
# Fiducial-Started Event Frame Sequencer

This block is the sending end of a broadcast timing link. A host loads a small table of scheduled events. Each entry pairs a tick offset, measured from the fiducial, with an 8-bit event code. The host also fills a ring of distributed-data bytes. Nothing is scheduled until a periodic fiducial pulse arrives, at a nominal 360 Hz, or roughly 2.8 ms apart. The fiducial resets a tick counter, and the table is then walked in index order. An entry's code goes onto the link in the cycle where the tick counter reaches that entry's offset.

The block sends one 16-bit frame on every cycle of the reference clock, which is one word per 8.4 ns at 119 MHz. The upper byte carries the event code and the lower byte carries data. When no event is due, the code byte is null (0x00). A frame input from an upstream generator lets several generators be chained. A locally due event always wins over the upstream code. The upstream frame passes through only in a cycle where this generator has nothing to send. Serialising, line coding and the transceiver sit outside this block.

Top module: `evseq_top`

## Requirements
- R1: While reset is asserted and in the first output after reset is released, the frame output is 0x0000 and the overrun flag is 0.
- R2: One frame is registered per clock, with the code in bits [15:8] and the data in bits [7:0]. If there is no local event and the upstream code is null (0x00), the code byte is 0x00.
- R3: A fiducial is sampled at clock edge k and starts the tick counter at 0. An entry with offset d then appears on the frame output from edge k+1+d.
- R4: Entries are taken in index order starting at 0, one entry per match. Each code is sent exactly once, when the tick counter equals that entry's offset. An entry whose code is 0x00 is consumed without sending anything.
- R5: An entry with code 0x7F ends playback in the cycle it matches. 0x7F is never sent for it, and no later entry is played until the next fiducial.
- R6: Playback also ends once the last table entry (index 2^EV_AW-1) has been sent.
- R7: No entry is played before the first fiducial. Writing the table does not start playback.
- R8: A locally due code wins over any upstream code. When there is no local code, the whole upstream frame is forwarded unchanged if its code byte is non-zero.
- R9: A fiducial that arrives during playback restarts playback from entry 0 with tick 0 and sets overrun_o, which stays set until reset. The frame for the cycle in which that fiducial arrives is still built from the old sequence.
- R10: Whenever the upstream frame is not forwarded, the data byte comes from the data buffer. The buffer read index starts at 0 in the first cycle after reset, advances by one every clock, and wraps after DB_DEPTH-1.
- R11: A host write to the event table or to the data buffer takes effect in the following cycle. A read of the same location in the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one frame per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fid_i | input | 1 | Fiducial pulse, sampled on the clock |
| ev_we_i | input | 1 | Event table write strobe |
| ev_waddr_i | input | EV_AW | Event table entry index |
| ev_wofs_i | input | 16 | Tick offset to store |
| ev_wcode_i | input | 8 | Event code to store |
| db_we_i | input | 1 | Data buffer write strobe |
| db_waddr_i | input | $clog2(DB_DEPTH) | Data buffer byte index |
| db_wdata_i | input | 8 | Data byte to store |
| up_frame_i | input | 16 | Frame from the upstream generator |
| frame_o | output | 16 | Outgoing frame: code [15:8], data [7:0] |
| overrun_o | output | 1 | Sticky flag: a fiducial arrived during playback |

## Verification
Two kinds of collision are the focus. The first is a local event falling due while the upstream frame carries a non-zero code. The second is a fiducial landing in the same cycle as a scheduled entry. Both are provoked by directed runs that place an upstream code and a second fiducial on exact edges. A random phase then mixes upstream codes, fiducials and host writes freely. Each frame is judged against a cycle model in the bench, and the check confirms that the old sequence's frame still leaves in the fiducial cycle before the restart takes effect.

// File: rtl/evseq_pkg.sv
// Shared constants and types for the event frame sequencer.
package evseq_pkg;
    localparam int OFS_W  = 16;
    localparam int CODE_W = 8;
    localparam int DATA_W = 8;
    localparam int FRAME_W = CODE_W + DATA_W;

    localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
    localparam logic [CODE_W-1:0] CODE_END  = 8'h7F;

    // One scheduled event: tick offset from the fiducial plus its code.
    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [CODE_W-1:0] code;
    } ev_entry_t;
endpackage

// File: rtl/evseq_evmem.sv
// Event table: host-written entries with one asynchronous read port.
// Assumes one write per cycle; a read in the write cycle sees the old value.
module evseq_evmem
    import evseq_pkg::*;
#(
    parameter int EV_AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [EV_AW-1:0] wr_addr,
    input  ev_entry_t        wr_entry,
    input  logic [EV_AW-1:0] rd_addr,
    output ev_entry_t        rd_entry
);
    localparam int DEPTH = 1 << EV_AW;

    ev_entry_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Store one table entry when it is addressed by the host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en && (wr_addr == EV_AW'(i))) begin
                mem[i] <= wr_entry;
            end
        end
    end

    // Present the entry selected by the player.
    always_comb begin
        rd_entry = mem[rd_addr];
    end
endmodule

// File: rtl/evseq_dbuf.sv
// Distributed-data ring: host-written bytes read out one per clock.
// Assumes DB_DEPTH >= 2; writes to indices at or above DB_DEPTH are dropped.
module evseq_dbuf
    import evseq_pkg::*;
#(
    parameter int DB_DEPTH = 16,
    localparam int DB_AW = $clog2(DB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DB_AW-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] buf_q [DB_DEPTH];
    logic [DB_AW-1:0]  rd_ptr;

    for (genvar i = 0; i < DB_DEPTH; i++) begin : g_byte
        // Hold one data byte, replaced by a host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q[i] <= '0;
            end else if (wr_en && (wr_addr == DB_AW'(i))) begin
                buf_q[i] <= wr_data;
            end
        end
    end

    // Advance the read index every cycle and wrap at the buffer length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_ptr == DB_AW'(DB_DEPTH - 1)) begin
            rd_ptr <= '0;
        end else begin
            rd_ptr <= rd_ptr + DB_AW'(1);
        end
    end

    // Byte offered for the current frame.
    always_comb begin
        rd_data = buf_q[rd_ptr];
    end
endmodule

// File: rtl/evseq_player.sv
// Playback engine: counts ticks from the fiducial and walks the event table.
// Assumes offsets in the table rise with the index; an offset already passed
// is only matched again after the tick counter wraps.
module evseq_player
    import evseq_pkg::*;
#(
    parameter int EV_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fid,
    input  ev_entry_t         entry,
    output logic [EV_AW-1:0]  idx,
    output logic [OFS_W-1:0]  tick,
    output logic              active,
    output logic              overrun,
    output logic              loc_valid,
    output logic [CODE_W-1:0] loc_code
);
    localparam logic [EV_AW-1:0] LAST_IDX = {EV_AW{1'b1}};

    logic due;
    logic is_end;
    logic stop;

    // Decide whether the current entry fires this cycle and what it sends.
    always_comb begin
        due       = active && (entry.ofs == tick);
        is_end    = (entry.code == CODE_END);
        loc_valid = due && !is_end && (entry.code != CODE_NULL);
        loc_code  = loc_valid ? entry.code : CODE_NULL;
        stop      = due && (is_end || (idx == LAST_IDX));
    end

    // Sequence state: restart on fiducial, else tick and step through entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            tick    <= '0;
            active  <= 1'b0;
            overrun <= 1'b0;
        end else if (fid) begin
            idx     <= '0;
            tick    <= '0;
            active  <= 1'b1;
            overrun <= overrun | active;
        end else if (active) begin
            tick <= tick + OFS_W'(1);
            if (due) begin
                idx <= idx + EV_AW'(1);
            end
            if (stop) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evseq_merge.sv
// Output stage: picks the local code or the upstream frame and registers it.
// Assumes a null upstream code means the upstream slot is free.
module evseq_merge
    import evseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_valid,
    input  logic [CODE_W-1:0]  loc_code,
    input  logic [FRAME_W-1:0] up_frame,
    input  logic [DATA_W-1:0]  loc_data,
    output logic [FRAME_W-1:0] frame
);
    logic               up_live;
    logic [FRAME_W-1:0] frame_d;

    // Fixed priority: local event, then upstream frame, then an idle frame.
    always_comb begin
        up_live = (up_frame[FRAME_W-1:DATA_W] != CODE_NULL);
        if (loc_valid) begin
            frame_d = {loc_code, loc_data};
        end else if (up_live) begin
            frame_d = up_frame;
        end else begin
            frame_d = {CODE_NULL, loc_data};
        end
    end

    // Register the chosen frame for the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else begin
            frame <= frame_d;
        end
    end
endmodule

// File: rtl/evseq_top.sv
// Fiducial-started event frame sequencer: event table, data ring, playback
// engine and upstream merge. One 16-bit frame leaves per clock.
// Assumes the host loads the table before the fiducial it is meant for.
module evseq_top
    import evseq_pkg::*;
#(
    parameter int EV_AW    = 5,
    parameter int DB_DEPTH = 16,
    localparam int DB_AW   = $clog2(DB_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fid_i,
    input  logic               ev_we_i,
    input  logic [EV_AW-1:0]   ev_waddr_i,
    input  logic [OFS_W-1:0]   ev_wofs_i,
    input  logic [CODE_W-1:0]  ev_wcode_i,
    input  logic               db_we_i,
    input  logic [DB_AW-1:0]   db_waddr_i,
    input  logic [DATA_W-1:0]  db_wdata_i,
    input  logic [FRAME_W-1:0] up_frame_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               overrun_o
);
    ev_entry_t          wr_entry;
    ev_entry_t          cur_entry;
    logic [EV_AW-1:0]   play_idx;
    logic [OFS_W-1:0]   play_tick;
    logic               play_active;
    logic               loc_valid;
    logic [CODE_W-1:0]  loc_code;
    logic [DATA_W-1:0]  loc_data;

    // Pack the host write fields into a table entry.
    always_comb begin
        wr_entry.ofs  = ev_wofs_i;
        wr_entry.code = ev_wcode_i;
    end

    evseq_evmem #(.EV_AW(EV_AW)) u_evmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ev_we_i),
        .wr_addr  (ev_waddr_i),
        .wr_entry (wr_entry),
        .rd_addr  (play_idx),
        .rd_entry (cur_entry)
    );

    evseq_dbuf #(.DB_DEPTH(DB_DEPTH)) u_dbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (db_we_i),
        .wr_addr (db_waddr_i),
        .wr_data (db_wdata_i),
        .rd_data (loc_data)
    );

    evseq_player #(.EV_AW(EV_AW)) u_player (
        .clk       (clk),
        .rst_n     (rst_n),
        .fid       (fid_i),
        .entry     (cur_entry),
        .idx       (play_idx),
        .tick      (play_tick),
        .active    (play_active),
        .overrun   (overrun_o),
        .loc_valid (loc_valid),
        .loc_code  (loc_code)
    );

    evseq_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_valid (loc_valid),
        .loc_code  (loc_code),
        .up_frame  (up_frame_i),
        .loc_data  (loc_data),
        .frame     (frame_o)
    );
endmodule

// File: rtl/evseq_chk.sv
// Property checker for evseq_top, attached by bind below.
// Assumes synchronous active-low reset; history-based checks wait one cycle.
module evseq_chk
    import evseq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fid_i,
    input logic [FRAME_W-1:0] up_frame_i,
    input logic [FRAME_W-1:0] frame_o,
    input logic               overrun_o,
    input logic               play_active,
    input logic               loc_valid,
    input logic [CODE_W-1:0]  loc_code,
    input logic [OFS_W-1:0]   play_tick
);
    logic hist_ok;

    // Mark that the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_ok <= 1'b0;
        end else begin
            hist_ok <= 1'b1;
        end
    end

    AST_IDLE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(loc_valid) && ($past(up_frame_i[15:8]) == CODE_NULL))
        |-> (frame_o[15:8] == CODE_NULL)); // R2
    AST_FID_START: assert property (@(posedge clk) disable iff (!rst_n)
        fid_i |=> (play_active && (play_tick == '0))); // R3
    AST_END_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && (frame_o[15:8] == CODE_END)) |-> ($past(up_frame_i[15:8]) == CODE_END)); // R5
    AST_NO_PLAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !play_active |-> !loc_valid); // R7
    AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(loc_valid)) |-> (frame_o[15:8] == $past(loc_code))); // R8
    AST_UP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(loc_valid) && ($past(up_frame_i[15:8]) != CODE_NULL))
        |-> (frame_o == $past(up_frame_i))); // R8
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fid_i && play_active) |=> overrun_o); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R9
endmodule

bind evseq_top evseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fid_i       (fid_i),
    .up_frame_i  (up_frame_i),
    .frame_o     (frame_o),
    .overrun_o   (overrun_o),
    .play_active (play_active),
    .loc_valid   (loc_valid),
    .loc_code    (loc_code),
    .play_tick   (play_tick)
);

// File: tb/evseq_top_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, judged per cycle
// against a cycle model built from the requirements.
module evseq_top_bench;
    localparam int EV_AW = 5;
    localparam int EV_N  = 1 << EV_AW;
    localparam int DB_N  = 16;
    localparam int DB_AW = $clog2(DB_N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fid = 1'b0;
    logic             ev_we = 1'b0;
    logic [EV_AW-1:0] ev_waddr = '0;
    logic [15:0]      ev_wofs = '0;
    logic [7:0]       ev_wcode = '0;
    logic             db_we = 1'b0;
    logic [DB_AW-1:0] db_waddr = '0;
    logic [7:0]       db_wdata = '0;
    logic [15:0]      up = '0;
    logic [15:0]      frame;
    logic             ovr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit chk_en = 0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    evseq_top #(.EV_AW(EV_AW), .DB_DEPTH(DB_N)) u_evseq_top (
        .clk(clk), .rst_n(rst_n), .fid_i(fid),
        .ev_we_i(ev_we), .ev_waddr_i(ev_waddr), .ev_wofs_i(ev_wofs), .ev_wcode_i(ev_wcode),
        .db_we_i(db_we), .db_waddr_i(db_waddr), .db_wdata_i(db_wdata),
        .up_frame_i(up), .frame_o(frame), .overrun_o(ovr)
    );

    // Cycle model
    logic [15:0] m_ofs [EV_N];
    logic [7:0]  m_code [EV_N];
    logic [7:0]  m_buf [DB_N];
    int m_tick, m_idx, m_ptr;
    bit m_act, m_ovr;
    logic [15:0] exp_frame = '0;

    always @(posedge clk) begin
        logic [7:0] lc;
        bit due, stop;
        if (!rst_n) begin
            m_tick = 0; m_idx = 0; m_ptr = 0; m_act = 0; m_ovr = 0; exp_frame = '0;
            for (int i = 0; i < EV_N; i++) begin m_ofs[i] = '0; m_code[i] = '0; end
            for (int i = 0; i < DB_N; i++) m_buf[i] = '0;
        end else begin
            lc = 8'h00; due = 0; stop = 0;
            if (m_act && (m_ofs[m_idx] == m_tick[15:0])) begin
                due = 1;
                if (m_code[m_idx] == 8'h7F) stop = 1;
                else begin
                    lc = m_code[m_idx];
                    if (m_idx == EV_N - 1) stop = 1;
                end
            end
            if (lc != 8'h00)          exp_frame = {lc, m_buf[m_ptr]};
            else if (up[15:8] != 0)   exp_frame = up;
            else                      exp_frame = {8'h00, m_buf[m_ptr]};
            m_ptr = (m_ptr == DB_N - 1) ? 0 : m_ptr + 1;
            if (fid) begin
                if (m_act) m_ovr = 1;
                m_tick = 0; m_idx = 0; m_act = 1;
            end else if (m_act) begin
                m_tick = (m_tick + 1) & 16'hFFFF;
                if (due) m_idx++;
                if (stop) m_act = 0;
            end
            if (ev_we) begin m_ofs[ev_waddr] = ev_wofs; m_code[ev_waddr] = ev_wcode; end
            if (db_we) m_buf[db_waddr] = db_wdata;
        end
    end

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(cur_req, frame, exp_frame);
            check("R9", {15'd0, ovr}, {15'd0, m_ovr});
        end
    end

    task automatic wr_ev(int a, logic [15:0] o, logic [7:0] c);
        ev_we = 1; ev_waddr = EV_AW'(a); ev_wofs = o; ev_wcode = c;
        @(negedge clk); ev_we = 0;
    endtask

    task automatic wr_db(int a, logic [7:0] d);
        db_we = 1; db_waddr = DB_AW'(a); db_wdata = d;
        @(negedge clk); db_we = 0;
    endtask

    task automatic pulse_fid();
        fid = 1; @(negedge clk); fid = 0;
    endtask

    function automatic int buf_index(logic [7:0] v);
        for (int i = 0; i < DB_N; i++) if (8'(i * 17 + 3) == v) return i;
        return -1;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", frame, 16'h0000);
        check("R1", {15'd0, ovr}, 16'h0000);
        rst_n = 1;
        @(negedge clk);
        check("R1", frame, 16'h0000);
        chk_en = 1;

        // Load data ring and table; table writes must not start playback (R7)
        cur_req = "R11";
        for (int i = 0; i < DB_N; i++) wr_db(i, 8'(i * 17 + 3));
        wr_ev(0, 16'd2, 8'h11);
        wr_ev(1, 16'd5, 8'h22);
        wr_ev(2, 16'd6, 8'h33);
        wr_ev(3, 16'd9, 8'h7F);
        wr_ev(4, 16'd10, 8'h44);
        cur_req = "R7";
        for (int i = 0; i < 10; i++) begin
            check("R7", {8'h00, frame[15:8]}, 16'h0000);
            @(negedge clk);
        end

        // R10: data bytes follow the ring one per clock
        for (int i = 0; i < 20; i++) begin
            int j;
            j = buf_index(frame[7:0]);
            @(negedge clk);
            check("R10", {8'h00, frame[7:0]}, {8'h00, 8'(((j + 1) % DB_N) * 17 + 3)});
        end

        // R3/R4/R8/R5: playback with an upstream code present
        cur_req = "R8";
        up = 16'h55A0;
        pulse_fid();                       // sampled at edge k
        check("R7", {8'h00, frame[15:8]}, 16'h0055);
        repeat (3) @(negedge clk);         // edge k+3
        check("R3", {8'h00, frame[15:8]}, 16'h0011);
        @(negedge clk);
        check("R8", frame, 16'h55A0);
        repeat (2) @(negedge clk);         // edge k+6
        check("R4", {8'h00, frame[15:8]}, 16'h0022);
        @(negedge clk);
        check("R4", {8'h00, frame[15:8]}, 16'h0033);
        repeat (3) @(negedge clk);         // edge k+10, end entry
        check("R5", frame, 16'h55A0);
        @(negedge clk);
        check("R5", frame, 16'h55A0);
        check("R9", {15'd0, ovr}, 16'h0000);
        up = 16'h0000;
        repeat (4) @(negedge clk);
        check("R5", {8'h00, frame[15:8]}, 16'h0000);

        // R9: fiducial in the same cycle as a due entry, then overrun
        cur_req = "R9";
        pulse_fid();                       // edge k
        repeat (2) @(negedge clk);
        pulse_fid();                       // sampled at edge k+3, entry 0 due
        check("R9", {8'h00, frame[15:8]}, 16'h0011);
        @(negedge clk);
        check("R9", {15'd0, ovr}, 16'h0001);
        repeat (2) @(negedge clk);
        check("R9", {8'h00, frame[15:8]}, 16'h0011);
        repeat (12) @(negedge clk);
        check("R9", {15'd0, ovr}, 16'h0001);

        // R6: full table, consecutive offsets, no end marker
        cur_req = "R6";
        for (int i = 0; i < EV_N; i++) wr_ev(i, 16'(i), 8'(i + 1));
        pulse_fid();
        for (int i = 0; i < EV_N; i++) begin
            @(negedge clk);
            check("R4", {8'h00, frame[15:8]}, 16'(i + 1));
        end
        @(negedge clk);
        check("R6", {8'h00, frame[15:8]}, 16'h0000);
        repeat (5) @(negedge clk);

        // Random phase
        cur_req = "R2";
        begin
            int acc;
            acc = 0;
            for (int i = 0; i < EV_N; i++) begin
                int r;
                logic [7:0] c;
                acc += 1 + int'($urandom % 4);
                r = int'($urandom % 16);
                if (r == 0) c = 8'h7F;
                else if (r == 1) c = 8'h00;
                else begin
                    c = 8'(8'h01 + $urandom % 8'hFE);
                    if (c == 8'h7F) c = 8'h7E;
                end
                wr_ev(i, 16'(acc), c);
            end
        end
        for (int i = 0; i < 4000; i++) begin
            up = ($urandom % 10 < 3) ? 16'($urandom) : 16'($urandom % 256);
            fid = ($urandom % 120 == 0);
            db_we = ($urandom % 20 == 0);
            db_waddr = DB_AW'($urandom);
            db_wdata = 8'($urandom);
            ev_we = ($urandom % 60 == 0);
            ev_waddr = EV_AW'($urandom);
            ev_wofs = 16'($urandom % 100);
            ev_wcode = 8'($urandom);
            @(negedge clk);
        end
        fid = 0; db_we = 0; ev_we = 0; up = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule